// File: doc/BRIEF.md
# Dual Timebase Sweep Controller

This block produces the digital horizontal ramps for a display with two timebases. The main sweep A is a counter that steps once every `a_div_i + 1` clock ticks from zero to full scale. It then rests for a fixed hold-off and re-arms. When auto mode is selected, sweep A starts on a trigger or, if no trigger arrives within a fixed timeout, on its own, so the trace keeps refreshing. In normal mode it stays idle until a trigger arrives.

Sweep A also works as a programmable delay. Once its ramp reaches the delay count, sweep B becomes eligible to run. B either starts right away or arms and waits for the next trigger strobe. B usually steps much faster than A. It stops at its own full scale or when A ends, whichever comes first, and it runs at most once per A sweep.

A display-mode input chooses which ramp drives the deflection output. An intensify flag marks the stretch of A that B covers.

Top module: `dual_sweep`

## Requirements
- R1: With `auto_i` high and sweep A idle, A starts after `AUTO_TMO` consecutive idle cycles without a trigger. It repeats with period `2^RAMP_W*(a_div_i+1) + HOLDOFF + AUTO_TMO` cycles. A trigger seen while idle starts A in the next cycle.
- R2: With `auto_i` low, sweep A stays idle for as long as no trigger arrives, and every A sweep begins in the cycle after a trigger edge.
- R3: While A runs, `a_ramp_o` starts at 0 and advances by one every `a_div_i+1` cycles. `a_active_o` stays high for exactly `2^RAMP_W*(a_div_i+1)` cycles.
- R4: After A ends, `HOLDOFF` cycles follow in which triggers are ignored. Only then can A start again.
- R5: With `b_wait_i` low, `b_active_o` first rises in the cycle after the first cycle in which the running `a_ramp_o` is at least `dly_i`.
- R6: With `b_wait_i` high, B arms at that point. It starts in the cycle after the first trigger sampled while armed. Triggers seen before the delay expires have no effect on B.
- R7: B starts at 0 and advances every `b_div_i+1` cycles. It runs for `2^RAMP_W*(b_div_i+1)` cycles or until A ends, whichever is shorter. It does not restart within the same A sweep, and it is eligible again in the next one. B is never active while A is idle.
- R8: `sel_ramp_o` follows `disp_i`: 0 selects A, 1 selects A, 2 selects B, 3 selects A until the delay has expired in the current sweep and B from the next cycle on.
- R9: `intens_o` is high exactly in the cycles where B is active and `disp_i` equals 1.
- R10: After reset, both sweeps are inactive, both ramps and the selected ramp are 0, and `intens_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger strobe, sampled each cycle |
| auto_i | input | 1 | 1 = free-running auto mode, 0 = normal (triggered only) |
| b_wait_i | input | 1 | 1 = B waits for a trigger after the delay, 0 = B starts at delay |
| disp_i | input | 2 | Display mode: 0 A, 1 A intensified, 2 B, 3 mixed |
| dly_i | input | RAMP_W | Delay, in A ramp counts |
| a_div_i | input | RATE_W | A ticks per ramp step minus one |
| b_div_i | input | RATE_W | B ticks per ramp step minus one |
| a_ramp_o | output | RAMP_W | Sweep A ramp |
| b_ramp_o | output | RAMP_W | Sweep B ramp |
| a_active_o | output | 1 | Sweep A running |
| b_active_o | output | 1 | Sweep B running |
| intens_o | output | 1 | Intensify flag |
| sel_ramp_o | output | RAMP_W | Ramp chosen by the display mode |

## Verification
The table-driven part fires single normal-mode sweeps with four settings. The first has B finishing well inside A. The second has B cut short by the end of A. The third has a zero delay with both sweeps at full speed. The fourth has a long delay on a slow A. Together they separate the start cycle of B, its length, each ramp's step rate and the four display selections. Directed runs cover the auto timeout and the free-run period, a trigger that pre-empts the timeout, triggers that fall inside the hold-off, and the trigger-armed start of B with an early trigger that must not start it.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef enum logic [1:0] {
    A_IDLE = 2'd0,
    A_RUN  = 2'd1,
    A_HOLD = 2'd2
  } a_st_t;

  typedef enum logic [1:0] {
    B_WAIT = 2'd0,
    B_ARM  = 2'd1,
    B_RUN  = 2'd2,
    B_DONE = 2'd3
  } b_st_t;

  localparam logic [1:0] DSP_A    = 2'd0;
  localparam logic [1:0] DSP_AINT = 2'd1;
  localparam logic [1:0] DSP_B    = 2'd2;
  localparam logic [1:0] DSP_MIX  = 2'd3;

endpackage

// File: rtl/dsw_tick.sv
// Rate prescaler: emits one step every div_i+1 cycles while run_i is high.
module dsw_tick #(
  parameter int RATE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [RATE_W-1:0] div_i,
  output logic              step_o
);

  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              wrap;

  assign wrap   = (cnt_q == div_i);
  assign step_o = run_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dsw_main.sv
// Main sweep: idle / run / hold-off, with the auto timeout.
module dsw_main
  import dsw_pkg::*;
#(
  parameter int RAMP_W   = 10,
  parameter int AUTO_TMO = 5000,
  parameter int HOLDOFF  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              auto_i,
  input  logic              step_i,
  output logic              active_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              end_o
);

  localparam int TMO_W = $clog2(AUTO_TMO + 1);
  localparam int HLD_W = $clog2(HOLDOFF + 1);
  localparam logic [RAMP_W-1:0] RMAX    = '1;
  localparam logic [TMO_W-1:0]  TMO_TOP = TMO_W'(AUTO_TMO - 1);
  localparam logic [HLD_W-1:0]  HLD_TOP = HLD_W'(HOLDOFF - 1);

  a_st_t             st_q, st_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic [TMO_W-1:0]  tmo_q, tmo_d;
  logic [HLD_W-1:0]  hld_q, hld_d;
  logic              go;

  assign active_o = (st_q == A_RUN);
  assign ramp_o   = ramp_q;
  assign end_o    = active_o && step_i && (ramp_q == RMAX);
  assign go       = trig_i || (auto_i && (tmo_q == TMO_TOP));

  always_comb begin
    st_d   = st_q;
    ramp_d = ramp_q;
    tmo_d  = tmo_q;
    hld_d  = hld_q;
    case (st_q)
      A_IDLE: begin
        if (go) begin
          st_d   = A_RUN;
          ramp_d = '0;
          tmo_d  = '0;
        end else if (auto_i) begin
          tmo_d = tmo_q + 1'b1;
        end else begin
          tmo_d = '0;
        end
      end
      A_RUN: begin
        if (step_i) begin
          if (ramp_q == RMAX) begin
            st_d   = A_HOLD;
            ramp_d = '0;
            hld_d  = '0;
          end else begin
            ramp_d = ramp_q + 1'b1;
          end
        end
      end
      A_HOLD: begin
        if (hld_q == HLD_TOP) st_d  = A_IDLE;
        else                  hld_d = hld_q + 1'b1;
      end
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= A_IDLE;
      ramp_q <= '0;
      tmo_q  <= '0;
      hld_q  <= '0;
    end else begin
      st_q   <= st_d;
      ramp_q <= ramp_d;
      tmo_q  <= tmo_d;
      hld_q  <= hld_d;
    end
  end

endmodule

// File: rtl/dsw_delayed.sv
// Delayed sweep: waits for the delay along A, optionally for a trigger, runs once.
module dsw_delayed
  import dsw_pkg::*;
#(
  parameter int RAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_active_i,
  input  logic [RAMP_W-1:0] a_ramp_i,
  input  logic              a_end_i,
  input  logic [RAMP_W-1:0] dly_i,
  input  logic              wait_trig_i,
  input  logic              trig_i,
  input  logic              step_i,
  output logic              active_o,
  output logic [RAMP_W-1:0] ramp_o,
  output logic              past_dly_o
);

  localparam logic [RAMP_W-1:0] RMAX = '1;

  b_st_t             st_q, st_d;
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic              dly_met;

  assign active_o   = (st_q == B_RUN);
  assign ramp_o     = ramp_q;
  assign past_dly_o = (st_q != B_WAIT);
  assign dly_met    = a_active_i && !a_end_i && (a_ramp_i >= dly_i);

  always_comb begin
    st_d   = st_q;
    ramp_d = ramp_q;
    case (st_q)
      B_WAIT: begin
        ramp_d = '0;
        if (dly_met) st_d = wait_trig_i ? B_ARM : B_RUN;
      end
      B_ARM: begin
        if (a_end_i)     st_d = B_WAIT;
        else if (trig_i) st_d = B_RUN;
      end
      B_RUN: begin
        if (a_end_i) begin
          st_d   = B_WAIT;
          ramp_d = '0;
        end else if (step_i) begin
          if (ramp_q == RMAX) begin
            st_d   = B_DONE;
            ramp_d = '0;
          end else begin
            ramp_d = ramp_q + 1'b1;
          end
        end
      end
      B_DONE: begin
        if (a_end_i) st_d = B_WAIT;
      end
      default: st_d = B_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_WAIT;
      ramp_q <= '0;
    end else begin
      st_q   <= st_d;
      ramp_q <= ramp_d;
    end
  end

endmodule

// File: rtl/dual_sweep.sv
module dual_sweep
  import dsw_pkg::*;
#(
  parameter int RAMP_W   = 10,
  parameter int RATE_W   = 10,
  parameter int AUTO_TMO = 5000,
  parameter int HOLDOFF  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              auto_i,
  input  logic              b_wait_i,
  input  logic [1:0]        disp_i,
  input  logic [RAMP_W-1:0] dly_i,
  input  logic [RATE_W-1:0] a_div_i,
  input  logic [RATE_W-1:0] b_div_i,
  output logic [RAMP_W-1:0] a_ramp_o,
  output logic [RAMP_W-1:0] b_ramp_o,
  output logic              a_active_o,
  output logic              b_active_o,
  output logic              intens_o,
  output logic [RAMP_W-1:0] sel_ramp_o
);

  localparam int NSWEEP = 2;

  logic [NSWEEP-1:0] run_w, step_w;
  logic [RATE_W-1:0] div_w [NSWEEP];
  logic              a_act, b_act, a_end, b_past;
  logic [RAMP_W-1:0] a_ramp, b_ramp;

  assign run_w    = {b_act, a_act};
  assign div_w[0] = a_div_i;
  assign div_w[1] = b_div_i;

  for (genvar g = 0; g < NSWEEP; g++) begin : g_tick
    dsw_tick #(.RATE_W(RATE_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_w[g]),
      .div_i  (div_w[g]),
      .step_o (step_w[g])
    );
  end

  dsw_main #(.RAMP_W(RAMP_W), .AUTO_TMO(AUTO_TMO), .HOLDOFF(HOLDOFF)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .auto_i   (auto_i),
    .step_i   (step_w[0]),
    .active_o (a_act),
    .ramp_o   (a_ramp),
    .end_o    (a_end)
  );

  dsw_delayed #(.RAMP_W(RAMP_W)) u_delayed (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_active_i  (a_act),
    .a_ramp_i    (a_ramp),
    .a_end_i     (a_end),
    .dly_i       (dly_i),
    .wait_trig_i (b_wait_i),
    .trig_i      (trig_i),
    .step_i      (step_w[1]),
    .active_o    (b_act),
    .ramp_o      (b_ramp),
    .past_dly_o  (b_past)
  );

  always_comb begin
    case (disp_i)
      DSP_B:   sel_ramp_o = b_ramp;
      DSP_MIX: sel_ramp_o = b_past ? b_ramp : a_ramp;
      default: sel_ramp_o = a_ramp;
    endcase
  end

  assign intens_o   = b_act && (disp_i == DSP_AINT);
  assign a_ramp_o   = a_ramp;
  assign b_ramp_o   = b_ramp;
  assign a_active_o = a_act;
  assign b_active_o = b_act;

endmodule

// File: rtl/dsw_chk.sv
module dsw_chk #(
  parameter int RAMP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_i,
  input logic              auto_i,
  input logic [RAMP_W-1:0] dly_i,
  input logic [RAMP_W-1:0] a_ramp_o,
  input logic [RAMP_W-1:0] b_ramp_o,
  input logic              a_active_o,
  input logic              b_active_o,
  input logic              intens_o
);

  a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_active_o) |-> (a_ramp_o == '0));

  a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (a_active_o && $past(a_active_o)) |->
      (a_ramp_o == $past(a_ramp_o) || a_ramp_o == $past(a_ramp_o) + 1'b1));

  a_r2_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && $past(!auto_i) && $rose(a_active_o)) |-> $past(trig_i));

  a_r4_rest_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_active_o) |=> !a_active_o);

  a_r5_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_active_o) |-> ($past(a_ramp_o) >= $past(dly_i)));

  a_r7_inside_a: assert property (@(posedge clk) disable iff (!rst_n)
    b_active_o |-> a_active_o);

  a_r7_b_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_active_o) |-> (b_ramp_o == '0));

  a_r9_intens_in_a: assert property (@(posedge clk) disable iff (!rst_n)
    intens_o |-> a_active_o);

endmodule

bind dual_sweep dsw_chk #(.RAMP_W(RAMP_W)) u_dsw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_i     (trig_i),
  .auto_i     (auto_i),
  .dly_i      (dly_i),
  .a_ramp_o   (a_ramp_o),
  .b_ramp_o   (b_ramp_o),
  .a_active_o (a_active_o),
  .b_active_o (b_active_o),
  .intens_o   (intens_o)
);

// File: tb/test_dual_sweep.sv
module test_dual_sweep;

  localparam int RAMP_W   = 4;
  localparam int RATE_W   = 10;
  localparam int AUTO_TMO = 20;
  localparam int HOLDOFF  = 3;

  typedef struct packed {
    int ad; int bd; int dly; int disp; int bst; int bcnt; int alen;
  } vec_t;

  // a_div, b_div, delay, display, expected B start index, B cycles, A cycles
  localparam vec_t VEC [4] = '{
    '{3, 0, 4,  1, 17, 16, 64},
    '{1, 1, 2,  3, 5,  27, 32},
    '{0, 0, 0,  2, 1,  15, 16},
    '{7, 0, 10, 0, 81, 16, 128}
  };

  logic              clk = 1'b0;
  logic              rst_n, trig, auto_m, b_wait;
  logic [1:0]        disp;
  logic [RAMP_W-1:0] dly;
  logic [RATE_W-1:0] a_div, b_div;
  logic [RAMP_W-1:0] a_ramp, b_ramp, sel_ramp;
  logic              a_act, b_act, intens;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_sweep #(.RAMP_W(RAMP_W), .RATE_W(RATE_W), .AUTO_TMO(AUTO_TMO), .HOLDOFF(HOLDOFF)) i_dual_sweep (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .auto_i(auto_m), .b_wait_i(b_wait),
    .disp_i(disp), .dly_i(dly), .a_div_i(a_div), .b_div_i(b_div),
    .a_ramp_o(a_ramp), .b_ramp_o(b_ramp), .a_active_o(a_act), .b_active_o(b_act),
    .intens_o(intens), .sel_ramp_o(sel_ramp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, amis, bmis, smis, bfirst, bcnt, icnt;
    rst_n = 1'b0; trig = 1'b0; auto_m = 1'b0; b_wait = 1'b0;
    disp = 2'd0; dly = '0; a_div = '0; b_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(!a_act && !b_act && !intens, "R10 flags", {a_act, b_act, intens}, 0);
    chk(a_ramp == 0 && b_ramp == 0 && sel_ramp == 0, "R10 ramps", a_ramp + b_ramp + sel_ramp, 0);

    // R2: normal mode stays idle without a trigger
    n = 0;
    repeat (100) begin @(negedge clk); if (a_act) n++; end
    chk(n == 0, "R2 idle without trigger", n, 0);

    // Table walk: single triggered sweeps in normal mode
    foreach (VEC[i]) begin
      a_div = RATE_W'(VEC[i].ad); b_div = RATE_W'(VEC[i].bd);
      dly = RAMP_W'(VEC[i].dly); disp = 2'(VEC[i].disp);
      repeat (2) @(negedge clk);
      pulse_trig();
      n = 0; amis = 0; bmis = 0; smis = 0; bfirst = -1; bcnt = 0; icnt = 0;
      while (a_act && n < 400) begin
        int exp_sel;
        if (int'(a_ramp) != n / (VEC[i].ad + 1)) amis++;
        if (b_act) begin
          if (bfirst < 0) bfirst = n;
          bcnt++;
          if (int'(b_ramp) != (n - VEC[i].bst) / (VEC[i].bd + 1)) bmis++;
        end
        if (intens) icnt++;
        case (VEC[i].disp)
          2: exp_sel = int'(b_ramp);
          3: exp_sel = (n < VEC[i].bst) ? int'(a_ramp) : int'(b_ramp);
          default: exp_sel = int'(a_ramp);
        endcase
        if (int'(sel_ramp) != exp_sel) smis++;
        n++;
        @(negedge clk);
      end
      chk(n == VEC[i].alen, "R3 A sweep length", n, VEC[i].alen);
      chk(amis == 0, "R3 A ramp steps", amis, 0);
      chk(bfirst == VEC[i].bst, "R5 B start cycle", bfirst, VEC[i].bst);
      chk(bcnt == VEC[i].bcnt, "R7 B run length", bcnt, VEC[i].bcnt);
      chk(bmis == 0, "R7 B ramp steps", bmis, 0);
      chk(smis == 0, "R8 selected ramp", smis, 0);
      chk(icnt == ((VEC[i].disp == 1) ? VEC[i].bcnt : 0), "R9 intensify cycles",
          icnt, (VEC[i].disp == 1) ? VEC[i].bcnt : 0);
      repeat (6) @(negedge clk);
    end

    // R4: triggers during hold-off are ignored
    a_div = '0; b_div = '0; dly = '0; disp = 2'd0;
    pulse_trig();
    n = 0;
    while (a_act && n < 400) begin n++; @(negedge clk); end
    trig = 1'b1;
    repeat (HOLDOFF) @(negedge clk);
    trig = 1'b0;
    n = 0;
    repeat (10) begin @(negedge clk); if (a_act) n++; end
    chk(n == 0, "R4 hold-off ignores triggers", n, 0);
    pulse_trig();
    chk(a_act, "R4 trigger after hold-off", a_act, 1);
    while (a_act) @(negedge clk);
    repeat (6) @(negedge clk);

    // R1: auto timeout, free-run period, trigger pre-empting the timeout
    auto_m = 1'b1;
    n = 0;
    while (!a_act && n < 400) begin @(negedge clk); n++; end
    chk(n == AUTO_TMO, "R1 auto timeout", n, AUTO_TMO);
    n = 0;
    while (a_act && n < 400) begin @(negedge clk); n++; end
    while (!a_act && n < 400) begin @(negedge clk); n++; end
    chk(n == 16 + HOLDOFF + AUTO_TMO, "R1 free-run period", n, 16 + HOLDOFF + AUTO_TMO);
    while (a_act) @(negedge clk);
    repeat (HOLDOFF) @(negedge clk);
    chk(!a_act, "R1 idle before trigger", a_act, 0);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(a_act, "R1 trigger starts auto sweep", a_act, 1);
    auto_m = 1'b0;
    while (a_act) @(negedge clk);
    repeat (6) @(negedge clk);

    // R6: B waits for a trigger after the delay; an early trigger is ignored
    b_wait = 1'b1; a_div = 10'd3; b_div = '0; dly = 4'd2;
    pulse_trig();
    n = 0; bfirst = -1; bcnt = 0;
    while (a_act && n < 400) begin
      if (b_act) begin if (bfirst < 0) bfirst = n; bcnt++; end
      trig = (n == 3 || n == 19);
      n++;
      @(negedge clk);
    end
    trig = 1'b0;
    chk(bfirst == 20, "R6 B starts after armed trigger", bfirst, 20);
    chk(bcnt == 16, "R6 armed B run length", bcnt, 16);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule